// File: doc/BRIEF.md
# Manchester Line Transmitter with Training Preamble

This block turns parallel characters into a Manchester-coded serial stream on a single output wire. Each character can be preceded by a training preamble and is always preceded by a start delimiter. The preamble has a programmable length and one of four patterns. The delimiter is either a single coded zero or a three-bit-time sync shape that breaks the coding rule. A bit-rate enable input, pulsing at twice the bit rate, advances the line one half-bit per pulse.

A character is offered with a valid/ready handshake. When a character is accepted, the block takes a snapshot of the configuration inputs: preamble pattern and length, polarity, delimiter mode and character length. The frame then runs to completion with that snapshot. A busy flag covers the whole frame, and the line rests high whenever no frame is in flight.

Top module: `mantx_top`

## Requirements
- R1: After reset, `line_out` is 1, `busy` is 0 and `in_ready` is 1. Whenever `busy` is 0, `line_out` is 1.
- R2: With `cfg_invert`=0, a coded bit takes two consecutive `half_tick` pulses. A 0 is driven low then high, and a 1 is driven high then low. `line_out` changes only on a clock edge where `half_tick` is 1.
- R3: With `cfg_invert`=1, every coded bit (preamble, one-bit delimiter, data) has its halves swapped: a 0 is high then low, and a 1 is low then high.
- R4: Data bits are sent least significant bit first. `cfg_len_code` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits, and the upper bits of `in_data` are not sent.
- R5: `cfg_pre_len` (0 to 15) sets the number of preamble bits. A value of 0 sends no preamble.
- R6: `cfg_pre_kind` selects the preamble bit sequence: 0 = all ones, 1 = all zeros, 2 = alternating starting with 1, 3 = alternating starting with 0. Each preamble bit is coded like a data bit.
- R7: With `cfg_sync_mode`=0, the delimiter is one coded logic 0.
- R8: With `cfg_sync_mode`=1, the delimiter is three half-bits low followed by three half-bits high, whatever the value of `cfg_invert`.
- R9: A frame is sent in this order: preamble, then delimiter, then data.
- R10: `busy` rises on the edge that accepts a character. The `half_tick` after the last data half-bit returns `line_out` to 1 and clears `busy`.
- R11: The configuration and `in_data` are captured at acceptance. Changes to them while `busy` is 1 do not alter the frame in flight.
- R12: `in_ready` is 0 while `busy` is 1, and `in_valid` asserted during a frame does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | Enable at twice the bit rate, one half-bit per pulse |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The transmitter is idle and can accept a character |
| in_data | input | CHAR_W | Character, least significant bit sent first |
| cfg_pre_kind | input | 2 | Preamble pattern select |
| cfg_pre_len | input | 4 | Preamble length in bits, 0 for none |
| cfg_invert | input | 1 | Swap the coding polarity |
| cfg_sync_mode | input | 1 | 1 selects the sync delimiter, 0 the one-bit delimiter |
| cfg_len_code | input | 2 | Character length, 5 plus the code |
| line_out | output | 1 | Registered serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
The bench targets these corner cases:

- **Preamble length boundaries.** It covers lengths 0, 1 and 15. A design that is off by one in the length compare would send one preamble bit too many or too few. A design that ignores the length of 0 would emit a stray preamble bit.
- **Alternating patterns.** Both alternating patterns are checked. A design that starts with the wrong phase would show the first preamble bit inverted.
- **Sync delimiter under inverted polarity.** A design that wrongly applies the polarity to the sync shape would drive high-then-low instead of low-then-high.
- **Configuration changes mid-frame.** Every configuration input and `in_data` are changed during a frame, and `in_valid` is held high throughout. A design without the snapshot, or one that accepts while busy, would corrupt the frame or start a second one.

// File: rtl/mantx_pkg.sv
package mantx_pkg;

  localparam int PRE_LEN_W  = 4;
  localparam int LEN_CODE_W = 2;
  localparam int MIN_CHAR   = 5;
  localparam int SUB_W      = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_DATA,
    ST_END
  } tx_state_e;

  typedef struct packed {
    logic [1:0]            pre_kind;
    logic [PRE_LEN_W-1:0]  pre_len;
    logic                  invert;
    logic                  sync_mode;
    logic [LEN_CODE_W-1:0] len_code;
  } tx_cfg_t;

  // Level of one half of a coded bit: first half equals bit xor polarity.
  function automatic logic half_level(input logic bit_v, input logic inv,
                                      input logic second);
    logic first;
    first = bit_v ^ inv;
    return second ? ~first : first;
  endfunction

  // Logical value of preamble bit number idx (only its parity matters).
  function automatic logic pre_bit(input logic [1:0] kind, input logic idx_odd);
    case (kind)
      2'd0:    return 1'b1;
      2'd1:    return 1'b0;
      2'd2:    return ~idx_odd;
      default: return idx_odd;
    endcase
  endfunction

  // Number of data bits for a length code.
  function automatic logic [3:0] char_bits(input logic [LEN_CODE_W-1:0] code);
    return 4'(MIN_CHAR) + 4'(code);
  endfunction

endpackage

// File: rtl/mantx_shift.sv
module mantx_shift #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_data,
  input  logic              advance,
  output logic              lsb
);
  logic [CHAR_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (load)    sr_q <= load_data;
    else if (advance) sr_q <= {1'b0, sr_q[CHAR_W-1:1]};
  end

  assign lsb = sr_q[0];

  // R11: the shift register moves only on a load or a data-bit boundary
  assert_shift_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !advance |=> $stable(sr_q));
endmodule

// File: rtl/mantx_seq.sv
module mantx_seq
  import mantx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  tx_cfg_t cfg_in,
  input  logic    tick,
  input  logic    data_lsb,
  output logic    busy,
  output logic    drive_fire,
  output logic    drive_level,
  output logic    mid_fire,
  output logic    end_fire,
  output logic    data_adv
);
  tx_state_e       st_q;
  tx_cfg_t         cfg_q;
  logic [3:0]      idx_q;
  logic [SUB_W-1:0] sub_q;
  logic [3:0]      nbits;
  logic            sync_sfd;
  logic            pre_last, data_last, sfd_last;

  assign nbits     = char_bits(cfg_q.len_code);
  assign sync_sfd  = (st_q == ST_SFD) && cfg_q.sync_mode;
  assign pre_last  = (idx_q == cfg_q.pre_len - 4'd1);
  assign data_last = (idx_q == nbits - 4'd1);
  assign sfd_last  = cfg_q.sync_mode ? (sub_q == 3'd5) : (sub_q == 3'd1);
  assign busy      = (st_q != ST_IDLE);

  always_comb begin
    drive_fire = tick && (st_q == ST_PRE || st_q == ST_SFD || st_q == ST_DATA);
    end_fire   = tick && (st_q == ST_END);
    mid_fire   = drive_fire && sub_q[0] && !sync_sfd;
    data_adv   = drive_fire && (st_q == ST_DATA) && sub_q[0];
    case (st_q)
      ST_PRE:  drive_level = half_level(pre_bit(cfg_q.pre_kind, idx_q[0]),
                                        cfg_q.invert, sub_q[0]);
      ST_SFD:  drive_level = cfg_q.sync_mode ? (sub_q >= 3'd3)
                                             : half_level(1'b0, cfg_q.invert, sub_q[0]);
      ST_DATA: drive_level = half_level(data_lsb, cfg_q.invert, sub_q[0]);
      default: drive_level = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cfg_q <= '0;
      idx_q <= '0;
      sub_q <= '0;
    end else if (start) begin
      cfg_q <= cfg_in;
      st_q  <= (cfg_in.pre_len != '0) ? ST_PRE : ST_SFD;
      idx_q <= '0;
      sub_q <= '0;
    end else if (tick) begin
      case (st_q)
        ST_PRE: begin
          if (sub_q[0]) begin
            sub_q <= '0;
            if (pre_last) begin
              st_q  <= ST_SFD;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 4'd1;
            end
          end else begin
            sub_q <= 3'd1;
          end
        end
        ST_SFD: begin
          if (sfd_last) begin
            st_q  <= ST_DATA;
            sub_q <= '0;
            idx_q <= '0;
          end else begin
            sub_q <= sub_q + 3'd1;
          end
        end
        ST_DATA: begin
          if (sub_q[0]) begin
            sub_q <= '0;
            if (data_last) st_q <= ST_END;
            else           idx_q <= idx_q + 4'd1;
          end else begin
            sub_q <= 3'd1;
          end
        end
        ST_END:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10: an accepted character makes the block busy on the next cycle
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R5: preamble bit counter never passes the programmed length
  assert_pre_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_PRE |-> (cfg_q.pre_len != '0) && (idx_q < cfg_q.pre_len));
  // R4: data bit counter stays below the selected character length
  assert_data_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_DATA |-> idx_q < nbits);
  // R12: no new character is taken while a frame is running
  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/mantx_line.sv
module mantx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_fire,
  input  logic drive_level,
  input  logic mid_fire,
  input  logic end_fire,
  output logic line_out
);
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          line_q <= 1'b1;
    else if (end_fire)   line_q <= 1'b1;
    else if (drive_fire) line_q <= drive_level;
  end

  assign line_out = line_q;

  // R2: every coded bit toggles the line at its mid-point
  assert_mid_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mid_fire |=> line_out != $past(line_out));
  // R2: without a half-bit event the line holds its level
  assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_fire && !end_fire |=> $stable(line_out));
  // R10: closing the frame leaves the line high
  assert_end_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_fire |=> line_out);
endmodule

// File: rtl/mantx_top.sv
module mantx_top
  import mantx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  half_tick,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [CHAR_W-1:0]     in_data,
  input  logic [1:0]            cfg_pre_kind,
  input  logic [PRE_LEN_W-1:0]  cfg_pre_len,
  input  logic                  cfg_invert,
  input  logic                  cfg_sync_mode,
  input  logic [LEN_CODE_W-1:0] cfg_len_code,
  output logic                  line_out,
  output logic                  busy
);
  tx_cfg_t cfg_in;
  logic    accept;
  logic    data_lsb, drive_fire, drive_level, mid_fire, end_fire, data_adv;

  assign cfg_in   = '{pre_kind: cfg_pre_kind, pre_len: cfg_pre_len,
                      invert: cfg_invert, sync_mode: cfg_sync_mode,
                      len_code: cfg_len_code};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  mantx_shift #(.CHAR_W(CHAR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(in_data),
    .advance(data_adv), .lsb(data_lsb)
  );

  mantx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .cfg_in(cfg_in), .tick(half_tick),
    .data_lsb(data_lsb), .busy(busy), .drive_fire(drive_fire),
    .drive_level(drive_level), .mid_fire(mid_fire), .end_fire(end_fire),
    .data_adv(data_adv)
  );

  mantx_line u_line (
    .clk(clk), .rst_n(rst_n), .drive_fire(drive_fire), .drive_level(drive_level),
    .mid_fire(mid_fire), .end_fire(end_fire), .line_out(line_out)
  );

  // R1: an idle transmitter keeps the line high
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out);
  // R11: busy starts only from an accepted handshake
  assert_busy_from_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));
endmodule

// File: tb/mantx_top_tb.sv
module mantx_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_pre_kind = '0;
  logic [3:0] cfg_pre_len = '0;
  logic       cfg_invert = 1'b0;
  logic       cfg_sync_mode = 1'b0;
  logic [1:0] cfg_len_code = 2'd3;
  logic       line_out;
  logic       busy;

  int n_checks = 0;
  int n_fail = 0;
  logic exp_q [0:63];
  int   n_exp;

  always #5 clk = ~clk;

  mantx_top #(.CHAR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cfg_pre_kind(cfg_pre_kind),
    .cfg_pre_len(cfg_pre_len), .cfg_invert(cfg_invert),
    .cfg_sync_mode(cfg_sync_mode), .cfg_len_code(cfg_len_code),
    .line_out(line_out), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // A coded bit: polarity-adjusted value first, its complement second.
  task automatic push_sym(input logic v, input logic inv);
    exp_q[n_exp]     = v ^ inv;
    exp_q[n_exp + 1] = ~(v ^ inv);
    n_exp += 2;
  endtask

  task automatic one_tick();
    @(negedge clk) half_tick = 1'b1;
    @(negedge clk) half_tick = 1'b0;
  endtask

  task automatic run_frame(input string req, input logic [7:0] d, input logic [1:0] kind,
                           input logic [3:0] plen, input logic inv, input logic sync,
                           input logic [1:0] lcode, input bit disturb);
    n_exp = 0;
    for (int i = 0; i < plen; i++) begin
      logic pb;
      case (kind)
        2'd0: pb = 1'b1;
        2'd1: pb = 1'b0;
        2'd2: pb = (i % 2 == 0);
        default: pb = (i % 2 == 1);
      endcase
      push_sym(pb, inv);
    end
    if (sync) begin
      for (int i = 0; i < 6; i++) exp_q[n_exp + i] = (i >= 3);
      n_exp += 6;
    end else begin
      push_sym(1'b0, inv);
    end
    for (int i = 0; i < 5 + lcode; i++) push_sym(d[i], inv);

    @(negedge clk);
    in_data = d; cfg_pre_kind = kind; cfg_pre_len = plen; cfg_invert = inv;
    cfg_sync_mode = sync; cfg_len_code = lcode; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "busy after accept", busy, 1);
    chk("R10", "line before first tick", line_out, 1);
    if (disturb) begin
      in_data = ~d; cfg_pre_kind = kind ^ 2'd1; cfg_pre_len = plen ^ 4'd5;
      cfg_invert = ~inv; cfg_sync_mode = ~sync; cfg_len_code = lcode ^ 2'd3;
      in_valid = 1'b1;
    end
    for (int k = 0; k < n_exp; k++) begin
      one_tick();
      chk(req, $sformatf("half %0d", k), line_out, exp_q[k]);
      chk("R10", "busy mid frame", busy, 1);
      if (disturb) chk("R12", "in_ready while busy", in_ready, 0);
      if (k == 0) begin
        repeat (2) @(negedge clk);
        chk("R2", "line holds between ticks", line_out, exp_q[0]);
      end
    end
    if (disturb) in_valid = 1'b0;
    one_tick();
    chk("R10", "line after frame", line_out, 1);
    chk("R10", "busy after frame", busy, 0);
    chk("R1", "in_ready after frame", in_ready, 1);
    if (disturb) begin
      one_tick();
      chk("R12", "no second frame", busy, 0);
      chk("R12", "line idle", line_out, 1);
    end
  endtask

  task automatic t_reset();
    chk("R1", "reset line", line_out, 1);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset in_ready", in_ready, 1);
  endtask

  task automatic t_default_polarity();
    run_frame("R2", 8'hA5, 2'd0, 4'd0, 1'b0, 1'b0, 2'd3, 1'b0);
    run_frame("R7", 8'h3C, 2'd0, 4'd0, 1'b0, 1'b0, 2'd3, 1'b0);
  endtask

  task automatic t_invert();
    run_frame("R3", 8'hA5, 2'd2, 4'd3, 1'b1, 1'b0, 2'd3, 1'b0);
  endtask

  task automatic t_lengths();
    run_frame("R4", 8'hF3, 2'd0, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    run_frame("R4", 8'hC1, 2'd0, 4'd0, 1'b1, 1'b0, 2'd1, 1'b0);
    run_frame("R4", 8'h96, 2'd0, 4'd0, 1'b0, 1'b0, 2'd2, 1'b0);
  endtask

  task automatic t_preamble();
    run_frame("R5", 8'h5A, 2'd1, 4'd1, 1'b0, 1'b0, 2'd3, 1'b0);
    run_frame("R5", 8'h0F, 2'd2, 4'd15, 1'b0, 1'b0, 2'd3, 1'b0);
    for (int kk = 0; kk < 4; kk++)
      run_frame("R6", 8'h69, 2'(kk), 4'd4, 1'b0, 1'b0, 2'd3, 1'b0);
    run_frame("R9", 8'h81, 2'd3, 4'd5, 1'b0, 1'b1, 2'd2, 1'b0);
  endtask

  task automatic t_sync();
    run_frame("R8", 8'h55, 2'd0, 4'd0, 1'b0, 1'b1, 2'd3, 1'b0);
    run_frame("R8", 8'h2E, 2'd1, 4'd2, 1'b1, 1'b1, 2'd1, 1'b0);
  endtask

  task automatic t_cfg_change();
    run_frame("R11", 8'hB4, 2'd2, 4'd2, 1'b0, 1'b0, 2'd1, 1'b1);
    run_frame("R11", 8'h4B, 2'd3, 4'd6, 1'b1, 1'b1, 2'd2, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_polarity();
    t_invert();
    t_lengths();
    t_preamble();
    t_sync();
    t_cfg_change();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule